// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single down-counting timer channel with a W-bit count (16 by default). It advances only on cycles where the `tick` clock-enable is high. The host side writes an initial count together with an operating mode through a one-cycle `load` strobe. The channel then produces a live count value and a waveform output `out`. The output is shaped by the mode, which is one of the following:

- a one-shot that ends high;
- a rate generator with a one-tick low pulse;
- a square wave;
- a single strobe pulse.

The `gate` input pauses the count in some modes and retriggers it on a rising edge in others.

Control is a small state machine with five states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Nothing loaded since reset. |
| `ST_RUN` | Counting toward terminal count. |
| `ST_TERM` | One-shot finished, output held high. |
| `ST_STROBE` | Strobe pulse active, output low. |
| `ST_SPENT` | Strobe already issued. |

Transitions:

- load → `ST_RUN` from any state;
- retrigger → `ST_RUN`;
- `ST_RUN` → `ST_TERM` on the tick that takes the count from 1 to 0 in modes 0/1;
- `ST_RUN` → `ST_STROBE` on that same tick in modes 4/5;
- `ST_STROBE` → `ST_SPENT` on the next counting tick.

`ST_TERM` and `ST_SPENT` hold until a load or a retrigger. Modes 2 and 3 stay in `ST_RUN`. The BCD selection is captured and reported back but has no effect on counting. A separate register-interface block owns host decoding and read latching.

Top module: `ivt_channel`

## Requirements
- R1: A cycle with `load` high captures `load_value`, the folded mode and `bcd_sel`. From the next cycle `count_out` equals `load_value`, and `tick` and `gate` are ignored in that cycle.
- R2: A loaded value of 0 stands for a count of 2^W. `count_out` shows 0 until the first counting tick, which makes it 2^W-1.
- R3: In modes 0, 1, 4 and 5 each counting tick lowers the count by one, and a count of 0 wraps to 2^W-1.
- R4: In modes 0 and 1 `out` is low from load or retrigger, goes high on the tick that brings the count to 0, and stays high through wrap-around until the next load or retrigger.
- R5: In mode 2 a tick at count 1 reloads the initial value, and `out` is low exactly while the count is 1.
- R6: In mode 3 each tick lowers the count by two. A tick at a count of 2 or less reloads the initial value and inverts `out`, and `out` is high after load or retrigger.
- R7: In modes 4 and 5 `out` is high except for one tick period after the count reaches 0, and this happens only once per load or retrigger.
- R8: In modes 0 and 4 ticks are ignored while `gate` is low, and the count holds.
- R9: In modes 1, 2, 3 and 5 a rising edge of `gate`, seen one cycle after it occurs, reloads the initial count and restores the post-load output.
- R10: In modes 0 and 4 a rising edge of `gate` does not reload the count.
- R11: Mode codes 6 and 7 behave as modes 2 and 3.
- R12: After reset and before the first load, `count_out` is 0, `out` is high, `bcd_flag` is 0, and ticks change nothing.
- R13: `bcd_flag` reports the `bcd_sel` captured at load, and counting stays binary when it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count clock enable |
| load | input | 1 | Load strobe for count, mode and BCD flag |
| load_value | input | W | Initial count (0 means 2^W) |
| mode_sel | input | 3 | Operating mode code 0..7 |
| bcd_sel | input | 1 | BCD flag to store |
| gate | input | 1 | Gate: pause (modes 0/4) or retrigger edge (1/2/3/5) |
| count_out | output | W | Live count value |
| out | output | 1 | Timer output waveform |
| bcd_flag | output | 1 | Stored BCD flag |

## Verification
The bench targets the zero-means-full-range load. A design that took zero literally would stop at once or show a wrong wrap value after the first tick. It checks the odd-count square wave, where a reload test written as "equals 2" would underflow past zero rather than reload from 1. It confirms that a mode-0 output stays high through wrap-around and that a strobe mode does not pulse a second time; a design that recomputed the output from the count alone would fail both. It also separates pausing gates from retriggering ones, so a gate edge reloading a mode-0 count, or a low gate stopping a mode-1 count, shows up as a wrong count value.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [2:0] {
        OP_TERM_IRQ  = 3'd0,
        OP_ONE_SHOT  = 3'd1,
        OP_RATE      = 3'd2,
        OP_SQUARE    = 3'd3,
        OP_SW_STROBE = 3'd4,
        OP_HW_STROBE = 3'd5
    } op_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_TERM   = 3'd2,
        ST_STROBE = 3'd3,
        ST_SPENT  = 3'd4
    } chan_state_t;

    // Codes 6 and 7 alias the periodic modes.
    function automatic op_mode_t fold_mode(input logic [2:0] sel);
        case (sel)
            3'd6:    fold_mode = OP_RATE;
            3'd7:    fold_mode = OP_SQUARE;
            default: fold_mode = op_mode_t'(sel);
        endcase
    endfunction

    function automatic logic gate_pauses(input op_mode_t m);
        gate_pauses = (m == OP_TERM_IRQ) || (m == OP_SW_STROBE);
    endfunction

    function automatic logic ends_sticky(input op_mode_t m);
        ends_sticky = (m == OP_TERM_IRQ) || (m == OP_ONE_SHOT);
    endfunction

    function automatic logic ends_strobe(input op_mode_t m);
        ends_strobe = (m == OP_SW_STROBE) || (m == OP_HW_STROBE);
    endfunction

endpackage

// File: rtl/ivt_gate_edge.sv
module ivt_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic rise
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate;
    end

    assign rise = gate & ~gate_q;
endmodule

// File: rtl/ivt_next_count.sv
module ivt_next_count
    import ivt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W:0]  cnt,
    input  logic [W:0]  init,
    input  op_mode_t    mode,
    output logic [W:0]  nxt,
    output logic        half_wrap
);
    localparam int CW = W + 1;
    localparam logic [CW-1:0] ONE = CW'(1);
    localparam logic [CW-1:0] TWO = CW'(2);

    logic [W-1:0] low_dec;

    assign low_dec   = cnt[W-1:0] - W'(1);
    assign half_wrap = (cnt <= TWO);

    always_comb begin
        unique case (mode)
            OP_RATE:   nxt = (cnt == ONE) ? init : cnt - ONE;
            OP_SQUARE: nxt = half_wrap ? init : cnt - TWO;
            default:   nxt = {1'b0, low_dec};
        endcase
    end
endmodule

// File: rtl/ivt_chan_fsm.sv
module ivt_chan_fsm
    import ivt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        retrig,
    input  logic        adv,
    input  op_mode_t    mode,
    input  logic        cnt_is_one,
    output chan_state_t state
);
    chan_state_t state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (load || retrig) begin
            state_nxt = ST_RUN;
        end else if (adv) begin
            unique case (state)
                ST_RUN: begin
                    if (cnt_is_one && ends_sticky(mode))      state_nxt = ST_TERM;
                    else if (cnt_is_one && ends_strobe(mode)) state_nxt = ST_STROBE;
                end
                ST_STROBE: state_nxt = ST_SPENT;
                default:   state_nxt = state;
            endcase
        end
    end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_value,
    input  logic [2:0]   mode_sel,
    input  logic         bcd_sel,
    input  logic         gate,
    output logic [W-1:0] count_out,
    output logic         out,
    output logic         bcd_flag
);
    localparam int CW = W + 1;
    localparam logic [CW-1:0] FULL = {1'b1, {W{1'b0}}};
    localparam logic [CW-1:0] ONE  = CW'(1);

    op_mode_t    mode_q;
    chan_state_t state_q;
    logic [CW-1:0] cnt_q, init_q, cnt_nxt, load_full;
    logic        sq_q, bcd_q, gate_rise, half_wrap;
    logic        retrig, adv;

    ivt_gate_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (gate),
        .rise  (gate_rise)
    );

    ivt_next_count #(.W(W)) u_next (
        .cnt       (cnt_q),
        .init      (init_q),
        .mode      (mode_q),
        .nxt       (cnt_nxt),
        .half_wrap (half_wrap)
    );

    assign retrig = gate_rise && (state_q != ST_IDLE) && !gate_pauses(mode_q) && !load;
    assign adv    = tick && (state_q != ST_IDLE) && !load && !retrig
                    && (gate || !gate_pauses(mode_q));

    ivt_chan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .retrig     (retrig),
        .adv        (adv),
        .mode       (mode_q),
        .cnt_is_one (cnt_q == ONE),
        .state      (state_q)
    );

    assign load_full = (load_value == '0) ? FULL : {1'b0, load_value};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= OP_TERM_IRQ;
            bcd_q  <= 1'b0;
            init_q <= '0;
            cnt_q  <= '0;
            sq_q   <= 1'b1;
        end else if (load) begin
            mode_q <= fold_mode(mode_sel);
            bcd_q  <= bcd_sel;
            init_q <= load_full;
            cnt_q  <= load_full;
            sq_q   <= 1'b1;
        end else if (retrig) begin
            cnt_q  <= init_q;
            sq_q   <= 1'b1;
        end else if (adv) begin
            cnt_q  <= cnt_nxt;
            if (mode_q == OP_SQUARE && half_wrap) sq_q <= ~sq_q;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   out = 1'b1;
            ST_TERM:   out = 1'b1;
            ST_STROBE: out = 1'b0;
            ST_SPENT:  out = 1'b1;
            default: begin
                unique case (mode_q)
                    OP_TERM_IRQ, OP_ONE_SHOT: out = 1'b0;
                    OP_RATE:                  out = (cnt_q != ONE);
                    OP_SQUARE:                out = sq_q;
                    default:                  out = 1'b1;
                endcase
            end
        endcase
    end

    assign count_out = cnt_q[W-1:0];
    assign bcd_flag  = bcd_q;
endmodule

// File: rtl/ivt_channel_chk.sv
module ivt_channel_chk
    import ivt_pkg::*;
#(
    parameter int W = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load,
    input logic [W-1:0]  load_value,
    input logic          gate,
    input logic [W-1:0]  count_out,
    input logic          out,
    input op_mode_t      mode_q,
    input chan_state_t   state_q,
    input logic [W:0]    cnt_q,
    input logic [W:0]    init_q,
    input logic          adv,
    input logic          retrig
);
    localparam logic [W:0] FULL = {1'b1, {W{1'b0}}};

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load) |=> (count_out == '0 && out));

    a_r1_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == (($past(load_value) == '0) ? FULL : {1'b0, $past(load_value)})));

    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (mode_q inside {OP_TERM_IRQ, OP_ONE_SHOT, OP_SW_STROBE, OP_HW_STROBE}))
        |=> (count_out == W'($past(count_out) - W'(1))));

    a_r6_half_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && mode_q == OP_SQUARE && cnt_q > (W+1)'(2)) |=> (cnt_q == $past(cnt_q) - (W+1)'(2)));

    a_r8_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !load && !gate && gate_pauses(mode_q)) |=> $stable(count_out));

    a_r4_term_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TERM && !load && !retrig) |=> out);

    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPENT && !load && !retrig) |=> out);

    a_r9_retrig_reload: assert property (@(posedge clk) disable iff (!rst_n)
        retrig |=> (cnt_q == $past(init_q)));
endmodule

bind ivt_channel ivt_channel_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_value (load_value),
    .gate       (gate),
    .count_out  (count_out),
    .out        (out),
    .mode_q     (mode_q),
    .state_q    (state_q),
    .cnt_q      (cnt_q),
    .init_q     (init_q),
    .adv        (adv),
    .retrig     (retrig)
);

// File: tb/ivt_channel_test.sv
module ivt_channel_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         load = 1'b0;
    logic [W-1:0] load_value = '0;
    logic [2:0]   mode_sel = '0;
    logic         bcd_sel = 1'b0;
    logic         gate = 1'b1;
    logic [W-1:0] count_out;
    logic         out;
    logic         bcd_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ivt_channel #(.W(W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (load),
        .load_value (load_value),
        .mode_sel   (mode_sel),
        .bcd_sel    (bcd_sel),
        .gate       (gate),
        .count_out  (count_out),
        .out        (out),
        .bcd_flag   (bcd_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_st(input string req, input int c, input int o);
        chk({req, " count"}, int'(count_out), c);
        chk({req, " out"}, int'(out), o);
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic do_load(input int v, input int m, input bit b);
        @(negedge clk);
        load = 1'b1; load_value = W'(v); mode_sel = 3'(m); bcd_sel = b; tick = 1'b1;
        @(negedge clk);
        load = 1'b0; tick = 1'b0; bcd_sel = 1'b0;
    endtask

    task automatic set_gate(input bit g);
        @(negedge clk) gate = g;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk_st("R12 reset", 0, 1);
        chk("R12 bcd_flag", int'(bcd_flag), 0);
        do_tick(); do_tick();
        chk_st("R12 idle tick", 0, 1);
    endtask

    task automatic t_mode0();
        do_load(5, 0, 1'b0);
        chk_st("R1 mode0 load", 5, 0);
        repeat (4) do_tick();
        chk_st("R3 mode0 at one", 1, 0);
        do_tick();
        chk_st("R4 mode0 terminal", 0, 1);
        do_tick();
        chk_st("R4 mode0 wrap sticky", 65535, 1);
        do_load(3, 0, 1'b0);
        chk_st("R4 mode0 reload low", 3, 0);
    endtask

    task automatic t_zero();
        do_load(0, 0, 1'b0);
        chk_st("R2 zero load", 0, 0);
        do_tick();
        chk_st("R2 zero first tick", 65535, 0);
    endtask

    task automatic t_gate_pause();
        do_load(4, 0, 1'b0);
        do_tick();
        set_gate(1'b0);
        do_tick(); do_tick(); do_tick();
        chk_st("R8 mode0 paused", 3, 0);
        set_gate(1'b1);
        chk_st("R10 mode0 no reload", 3, 0);
        do_tick();
        chk_st("R8 mode0 resumed", 2, 0);
        do_load(3, 4, 1'b0);
        set_gate(1'b0);
        do_tick();
        chk_st("R8 mode4 paused", 3, 1);
        set_gate(1'b1);
        chk_st("R10 mode4 no reload", 3, 1);
    endtask

    task automatic t_rate();
        do_load(3, 2, 1'b0);
        chk_st("R5 rate load", 3, 1);
        do_tick();
        chk_st("R5 rate two", 2, 1);
        do_tick();
        chk_st("R5 rate one low", 1, 0);
        do_tick();
        chk_st("R5 rate reload", 3, 1);
        do_tick(); do_tick();
        chk_st("R5 rate second low", 1, 0);
        do_tick();
        set_gate(1'b0);
        set_gate(1'b1);
        chk_st("R9 rate retrigger", 3, 1);
    endtask

    task automatic t_square();
        do_load(6, 3, 1'b0);
        chk_st("R6 square load", 6, 1);
        do_tick();
        chk_st("R6 square step", 4, 1);
        do_tick();
        chk_st("R6 square step2", 2, 1);
        do_tick();
        chk_st("R6 square half", 6, 0);
        do_tick(); do_tick(); do_tick();
        chk_st("R6 square full", 6, 1);
        do_load(5, 3, 1'b0);
        do_tick(); do_tick();
        chk_st("R6 square odd one", 1, 1);
        do_tick();
        chk_st("R6 square odd half", 5, 0);
        set_gate(1'b0);
        set_gate(1'b1);
        chk_st("R9 square retrigger", 5, 1);
    endtask

    task automatic t_strobe();
        do_load(2, 4, 1'b0);
        chk_st("R7 strobe load", 2, 1);
        do_tick();
        chk_st("R7 strobe one", 1, 1);
        do_tick();
        chk_st("R7 strobe pulse", 0, 0);
        do_tick();
        chk_st("R7 strobe end", 65535, 1);
        do_tick();
        chk_st("R7 strobe once", 65534, 1);
    endtask

    task automatic t_retrig();
        do_load(4, 1, 1'b0);
        set_gate(1'b0);
        do_tick(); do_tick();
        chk_st("R9 mode1 counts gate low", 2, 0);
        set_gate(1'b1);
        chk_st("R9 mode1 retrigger", 4, 0);
        repeat (4) do_tick();
        chk_st("R4 mode1 terminal", 0, 1);
        set_gate(1'b0);
        set_gate(1'b1);
        chk_st("R9 mode1 rearm", 4, 0);
        do_load(2, 5, 1'b0);
        do_tick(); do_tick();
        chk_st("R7 mode5 pulse", 0, 0);
        do_tick();
        chk_st("R7 mode5 end", 65535, 1);
        set_gate(1'b0);
        set_gate(1'b1);
        chk_st("R9 mode5 retrigger", 2, 1);
        do_tick(); do_tick();
        chk_st("R9 mode5 second pulse", 0, 0);
    endtask

    task automatic t_alias();
        do_load(3, 6, 1'b0);
        do_tick(); do_tick();
        chk_st("R11 mode6 as rate", 1, 0);
        do_tick();
        chk_st("R11 mode6 reload", 3, 1);
        do_load(4, 7, 1'b0);
        do_tick();
        chk_st("R11 mode7 step", 2, 1);
        do_tick();
        chk_st("R11 mode7 half", 4, 0);
    endtask

    task automatic t_bcd();
        do_load(16, 0, 1'b1);
        chk("R13 bcd stored", int'(bcd_flag), 1);
        do_tick();
        chk_st("R13 binary count", 15, 0);
        do_load(16, 0, 1'b0);
        chk("R13 bcd cleared", int'(bcd_flag), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode0();
        t_zero();
        t_gate_pause();
        t_rate();
        t_square();
        t_strobe();
        t_retrig();
        t_alias();
        t_bcd();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule